// File: doc/BRIEF.md
# Key-Locked GPIO Pad Mode Controller

This block is one bank of general-purpose pins, up to 32 wide, controlled through a small 32-bit register bus. Each pin carries two mode bits and one output data bit. Together these three bits choose between four pad behaviours: an input, a full push-pull driver, a pull-down-only (open-drain) driver and a pull-up-only (open-source) driver. The pad side of the block is a per-pin output enable and output level. Each pad input is also sampled through a two-flop synchronizer so that software can read it.

The mode bits are protected. They can be changed only while a lock register holds the unlock key. Software writes the key, changes the mode vectors through direct writes or through write-1 set and clear aliases, and then writes zero to lock them again. The output data register is not protected. Software changes it with write-1 set and clear operations.

The bank width is a parameter. Bits above the implemented pin count are dropped on write and read as zero.

Top module: `gkl_bank`

## Requirements
- R1: After reset, the lock is inactive, both mode vectors and the output data are zero, and every pad_oe bit is 0.
- R2: A write to offset 0x00 whose bits 15:0 equal 16'hD42F makes the lock active from the next cycle, whatever bits 31:16 hold. A read of offset 0x00 returns 32'h8000_0000 while the lock is active and 0 while it is not.
- R3: A write of 32'h0 to offset 0x00 makes the lock inactive from the next cycle.
- R4: Any other write to offset 0x00 leaves the lock state unchanged.
- R5: While the lock is inactive, writes to offsets 0x08, 0x0C, 0x50, 0x54 and 0x58 leave both mode vectors unchanged.
- R6: While the lock is active, a write to offset 0x08 replaces mode1 and a write to offset 0x0C replaces mode0. Reads of these offsets return the current vectors.
- R7: While the lock is active, offset 0x54 sets the mode0 bits written as 1, offset 0x58 clears the mode0 bits written as 1, and offset 0x50 clears the mode1 bits written as 1. Bits written as 0 are unchanged.
- R8: Offset 0x14 sets the output data bits written as 1, and offset 0x18 clears the output data bits written as 1, whether or not the lock is active. A read of offset 0x14 returns the output data.
- R9: For each pin with output data bit d, the {mode1,mode0} pair selects the pad behaviour as follows. 00 gives pad_oe=0. 01 gives pad_oe=1 and pad_out=d. 10 gives pad_oe=!d and pad_out=0. 11 gives pad_oe=d and pad_out=1. pad_out is 0 whenever pad_oe is 0.
- R10: pad_in passes through two flops. The value present at pad_in before a clock edge reads at offset 0x04 after the second rising edge, and not after the first.
- R11: Register bits at or above NUM_PINS are ignored on write and read as zero.
- R12: A write to any other offset changes no state. A read of any offset not named in R2, R6, R8 or R10 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pad_in | input | NUM_PINS | Asynchronous pad input levels |
| pad_oe | output | NUM_PINS | Per-pin pad output enable |
| pad_out | output | NUM_PINS | Per-pin pad output level |

## Verification
A lock that engages on the wrong key, or fails to engage on the right one, shows within one cycle. It shows on the status read, and it shows as a mode write that sticks or vanishes on the next readback. A wrong mode or data bit shows at once on pad_oe and pad_out, because the pad decode is combinational from the registers. A sweep over every mode pairing with several data patterns exposes any error in the four-way drive table. A synchronizer with the wrong depth shows as the data-in read changing one edge early or late.

// File: rtl/gkl_pkg.sv
package gkl_pkg;

  localparam int          REG_W    = 32;
  localparam logic [15:0] LOCK_KEY = 16'hD42F;

  // Register byte offsets
  localparam int OFS_LOCK     = 'h00;
  localparam int OFS_DIN      = 'h04;
  localparam int OFS_MODE1    = 'h08;
  localparam int OFS_MODE0    = 'h0C;
  localparam int OFS_DSET     = 'h14;
  localparam int OFS_DCLR     = 'h18;
  localparam int OFS_MODE1CLR = 'h50;
  localparam int OFS_MODE0SET = 'h54;
  localparam int OFS_MODE0CLR = 'h58;

  // One-hot write strobes from the address decoder
  typedef struct packed {
    logic lock;
    logic mode1;
    logic mode0;
    logic mode1_clr;
    logic mode0_set;
    logic mode0_clr;
    logic dset;
    logic dclr;
  } gkl_wr_t;

  function automatic logic key_hit(input logic [REG_W-1:0] wd);
    return wd[15:0] == LOCK_KEY;
  endfunction

  function automatic logic release_hit(input logic [REG_W-1:0] wd);
    return wd == '0;
  endfunction

  // Pad drive table: enable for {m1,m0} with data d
  function automatic logic pad_enable(input logic m1, input logic m0, input logic d);
    case ({m1, m0})
      2'b00:   return 1'b0;
      2'b01:   return 1'b1;
      2'b10:   return ~d;
      default: return d;
    endcase
  endfunction

  // Driven level; forced to 0 whenever the pad floats
  function automatic logic pad_level(input logic m1, input logic m0, input logic d);
    logic lvl;
    case ({m1, m0})
      2'b01:   lvl = d;
      2'b11:   lvl = 1'b1;
      default: lvl = 1'b0;
    endcase
    return lvl & pad_enable(m1, m0, d);
  endfunction

endpackage

// File: rtl/gkl_lock_ctrl.sv
module gkl_lock_ctrl
  import gkl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lock,
  input  logic [REG_W-1:0] wdata,
  output logic             lock_active
);

  logic acquire;
  logic release_req;

  assign acquire     = wr_lock && key_hit(wdata);
  assign release_req = wr_lock && release_hit(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lock_active <= 1'b0;
    else if (acquire)     lock_active <= 1'b1;
    else if (release_req) lock_active <= 1'b0;
  end

endmodule

// File: rtl/gkl_mode_regs.sv
module gkl_mode_regs
  import gkl_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lock_active,
  input  gkl_wr_t             wr,
  input  logic [NUM_PINS-1:0] wbits,
  output logic [NUM_PINS-1:0] mode0_q,
  output logic [NUM_PINS-1:0] mode1_q
);

  logic [NUM_PINS-1:0] mode0_d;
  logic [NUM_PINS-1:0] mode1_d;

  always_comb begin
    mode0_d = mode0_q;
    mode1_d = mode1_q;
    if (lock_active) begin
      if (wr.mode0)          mode0_d = wbits;
      else if (wr.mode0_set) mode0_d = mode0_q | wbits;
      else if (wr.mode0_clr) mode0_d = mode0_q & ~wbits;
      if (wr.mode1)          mode1_d = wbits;
      else if (wr.mode1_clr) mode1_d = mode1_q & ~wbits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode0_q <= '0;
      mode1_q <= '0;
    end else begin
      mode0_q <= mode0_d;
      mode1_q <= mode1_d;
    end
  end

endmodule

// File: rtl/gkl_data_regs.sv
module gkl_data_regs
  import gkl_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  gkl_wr_t             wr,
  input  logic [NUM_PINS-1:0] wbits,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] dout_q,
  output logic [NUM_PINS-1:0] din_sync
);

  logic [NUM_PINS-1:0] sync_q [SYNC_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout_q <= '0;
    else if (wr.dset) dout_q <= dout_q | wbits;
    else if (wr.dclr) dout_q <= dout_q & ~wbits;
  end

  for (genvar s = 0; s < SYNC_DEPTH; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= (s == 0) ? pad_in : sync_q[(s == 0) ? 0 : s - 1];
    end
  end

  assign din_sync = sync_q[SYNC_DEPTH-1];

endmodule

// File: rtl/gkl_pad_drive.sv
module gkl_pad_drive
  import gkl_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS-1:0] mode0,
  input  logic [NUM_PINS-1:0] mode1,
  input  logic [NUM_PINS-1:0] dout,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out
);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    assign pad_oe[p]  = pad_enable(mode1[p], mode0[p], dout[p]);
    assign pad_out[p] = pad_level(mode1[p], mode0[p], dout[p]);
  end

endmodule

// File: rtl/gkl_bank.sv
module gkl_bank
  import gkl_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic                reg_we,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out
);

  localparam int SYNC_DEPTH = 2;

  // Named internal events, observed by the bound checker
  gkl_wr_t             wr;
  logic                lock_active;
  logic [NUM_PINS-1:0] wbits;
  logic [NUM_PINS-1:0] mode0_q;
  logic [NUM_PINS-1:0] mode1_q;
  logic [NUM_PINS-1:0] dout_q;
  logic [NUM_PINS-1:0] din_sync;

  assign wbits = reg_wdata[NUM_PINS-1:0];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    wr           = '0;
    wr.lock      = reg_we && hit(reg_addr, OFS_LOCK);
    wr.mode1     = reg_we && hit(reg_addr, OFS_MODE1);
    wr.mode0     = reg_we && hit(reg_addr, OFS_MODE0);
    wr.mode1_clr = reg_we && hit(reg_addr, OFS_MODE1CLR);
    wr.mode0_set = reg_we && hit(reg_addr, OFS_MODE0SET);
    wr.mode0_clr = reg_we && hit(reg_addr, OFS_MODE0CLR);
    wr.dset      = reg_we && hit(reg_addr, OFS_DSET);
    wr.dclr      = reg_we && hit(reg_addr, OFS_DCLR);
  end

  gkl_lock_ctrl u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_lock     (wr.lock),
    .wdata       (reg_wdata),
    .lock_active (lock_active)
  );

  gkl_mode_regs #(.NUM_PINS(NUM_PINS)) u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_active (lock_active),
    .wr          (wr),
    .wbits       (wbits),
    .mode0_q     (mode0_q),
    .mode1_q     (mode1_q)
  );

  gkl_data_regs #(.NUM_PINS(NUM_PINS), .SYNC_DEPTH(SYNC_DEPTH)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr),
    .wbits    (wbits),
    .pad_in   (pad_in),
    .dout_q   (dout_q),
    .din_sync (din_sync)
  );

  gkl_pad_drive #(.NUM_PINS(NUM_PINS)) u_pad (
    .mode0   (mode0_q),
    .mode1   (mode1_q),
    .dout    (dout_q),
    .pad_oe  (pad_oe),
    .pad_out (pad_out)
  );

  // Read multiplexer; unimplemented bits and offsets read zero
  always_comb begin
    reg_rdata = '0;
    if (hit(reg_addr, OFS_LOCK))       reg_rdata[REG_W-1]    = lock_active;
    else if (hit(reg_addr, OFS_DIN))   reg_rdata[NUM_PINS-1:0] = din_sync;
    else if (hit(reg_addr, OFS_MODE1)) reg_rdata[NUM_PINS-1:0] = mode1_q;
    else if (hit(reg_addr, OFS_MODE0)) reg_rdata[NUM_PINS-1:0] = mode0_q;
    else if (hit(reg_addr, OFS_DSET))  reg_rdata[NUM_PINS-1:0] = dout_q;
  end

endmodule

// File: rtl/gkl_bank_checker.sv
module gkl_bank_checker
  import gkl_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic                reg_we,
  input logic [REG_W-1:0]    reg_wdata,
  input logic [NUM_PINS-1:0] pad_in,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_out,
  input logic                lock_active,
  input logic [NUM_PINS-1:0] mode0_q,
  input logic [NUM_PINS-1:0] mode1_q,
  input logic [NUM_PINS-1:0] din_sync
);

  logic [1:0] warm;
  logic       lock_wr;

  assign lock_wr = reg_we && (reg_addr == ADDR_W'(OFS_LOCK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  p_key_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_active) |-> $past(lock_wr && reg_wdata[15:0] == LOCK_KEY));

  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && reg_wdata == '0) |=> !lock_active);

  p_other_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && reg_wdata[15:0] != LOCK_KEY && reg_wdata != '0) |=> $stable(lock_active));

  p_mode_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_active |=> ($stable(mode0_q) && $stable(mode1_q)));

  p_input_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mode0_q & ~mode1_q & pad_oe) == '0) && ((pad_out & ~pad_oe) == '0));

  p_sync_depth_r10: assert property (@(posedge clk) disable iff (!rst_n)
    warm[1] |-> din_sync == $past(pad_in, 2));

endmodule

bind gkl_bank gkl_bank_checker #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/gkl_bank_bench.sv
module gkl_bank_bench;

  localparam int NP = 6;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_oe;
  logic [NP-1:0] pad_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gkl_bank #(.NUM_PINS(NP), .ADDR_W(AW)) u_gkl_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Expected pad behaviour, one pin at a time
  function automatic logic [1:0] exp_pin(input logic m1, input logic m0, input logic d);
    // returns {oe, out}
    if (!m1 && !m0) return 2'b00;
    if (!m1 &&  m0) return {1'b1, d};
    if ( m1 && !m0) return d ? 2'b00 : 2'b10;
    return d ? 2'b11 : 2'b00;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] r;
    logic [NP-1:0] eoe, eout;
    logic [NP-1:0] pats [3];
    pats[0] = 6'h00; pats[1] = 6'h3F; pats[2] = 6'h2A;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, r); check("R1 lock", r, 32'h0);
    rd(8'h08, r); check("R1 mode1", r, 32'h0);
    rd(8'h0C, r); check("R1 mode0", r, 32'h0);
    rd(8'h14, r); check("R1 dout", r, 32'h0);
    check("R1 pad_oe", {26'h0, pad_oe}, 32'h0);

    // R5 writes ignored while unlocked
    wr(8'h0C, 32'hFFFF_FFFF); wr(8'h54, 32'h3F); wr(8'h08, 32'h3F);
    rd(8'h0C, r); check("R5 mode0 locked", r, 32'h0);
    rd(8'h08, r); check("R5 mode1 locked", r, 32'h0);
    check("R5 pad_oe", {26'h0, pad_oe}, 32'h0);

    // R4 / R2 / R3 lock register
    wr(8'h00, 32'h0000_1234); rd(8'h00, r); check("R4 no key", r, 32'h0);
    wr(8'h00, 32'hABCD_D42F); rd(8'h00, r); check("R2 acquire", r, 32'h8000_0000);
    wr(8'h00, 32'h0000_0001); rd(8'h00, r); check("R4 hold active", r, 32'h8000_0000);
    wr(8'h00, 32'h0001_0000); rd(8'h00, r); check("R4 upper only", r, 32'h8000_0000);
    wr(8'h00, 32'h0);         rd(8'h00, r); check("R3 release", r, 32'h0);
    wr(8'h58, 32'h3F); wr(8'h50, 32'h3F);
    rd(8'h0C, r); check("R5 after release", r, 32'h0);
    wr(8'h00, 32'h0000_D42F); rd(8'h00, r); check("R2 reacquire", r, 32'h8000_0000);

    // R6 / R11 direct writes, width limit
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, r); check("R6 R11 mode0", r, 32'h3F);
    wr(8'h08, 32'hFFFF_FFC5); rd(8'h08, r); check("R6 R11 mode1", r, 32'h05);

    // R7 aliases
    wr(8'h0C, 32'h0F);
    wr(8'h54, 32'h30); rd(8'h0C, r); check("R7 mode0 set", r, 32'h3F);
    wr(8'h58, 32'h05); rd(8'h0C, r); check("R7 mode0 clr", r, 32'h3A);
    wr(8'h50, 32'h04); rd(8'h08, r); check("R7 mode1 clr", r, 32'h01);
    wr(8'h54, 32'h0);  rd(8'h0C, r); check("R7 zero set", r, 32'h3A);

    // R8 data set/clear, lock independent
    wr(8'h14, 32'h2A); rd(8'h14, r); check("R8 dset", r, 32'h2A);
    wr(8'h18, 32'h0A); rd(8'h14, r); check("R8 dclr", r, 32'h20);
    wr(8'h00, 32'h0);
    wr(8'h14, 32'hFFFF_FF01); rd(8'h14, r); check("R8 R11 dset unlocked", r, 32'h21);
    rd(8'h18, r); check("R12 dclr reads 0", r, 32'h0);
    wr(8'h00, 32'hD42F);

    // R12 unmapped offsets
    wr(8'h1C, 32'hFFFF_FFFF); wr(8'h4C, 32'hFFFF_FFFF);
    rd(8'h1C, r); check("R12 unmapped read", r, 32'h0);
    rd(8'h50, r); check("R12 alias read", r, 32'h0);
    rd(8'h0C, r); check("R12 mode0 kept", r, 32'h3A);
    rd(8'h14, r); check("R12 dout kept", r, 32'h21);

    // R10 synchronizer depth
    @(negedge clk); pad_in = 6'h2D;
    rd(8'h04, r); check("R10 one edge", r, 32'h0);
    rd(8'h04, r); check("R10 two edges", r, 32'h2D);
    @(negedge clk); pad_in = 6'h12;
    rd(8'h04, r); check("R10 one edge b", r, 32'h2D);
    rd(8'h04, r); check("R10 two edges b", r, 32'h12);

    // R9 sweep over every mode pairing and several data patterns
    for (int m1 = 0; m1 < 64; m1++) begin
      wr(8'h08, 32'(m1));
      for (int m0 = 0; m0 < 64; m0++) begin
        wr(8'h0C, 32'(m0));
        for (int k = 0; k < 3; k++) begin
          wr(8'h14, 32'(pats[k]));
          wr(8'h18, 32'(~pats[k]));
          for (int p = 0; p < NP; p++)
            {eoe[p], eout[p]} = exp_pin(1'(m1 >> p), 1'(m0 >> p), pats[k][p]);
          #1;
          check("R9 pad_oe", {26'h0, pad_oe}, {26'h0, eoe});
          check("R9 pad_out", {26'h0, pad_out}, {26'h0, eout});
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule